// File: doc/BRIEF.md
# Job Ring Doorbell Controller

This block runs one pair of descriptor rings for an offload engine. Software fills an inbound ring with job descriptors and tells the hardware how many it added by writing a count to a doorbell register. Completed descriptors go into an outbound ring. Software learns how many wait there from a count register, and it frees them by writing a count to a second doorbell. Software never writes ring indices. The hand-off between software and hardware uses only these counts.

Inside, a sequencer takes one inbound job at a time and issues it to the engine together with the descriptor address. It waits for a done pulse from the engine and then writes the completion into the next outbound slot. Jobs therefore finish in submission order. The states are OFF, IDLE, FETCH, RUN and POST. The transitions are:
- OFF to IDLE once the channel is enabled.
- IDLE to FETCH when a job is pending.
- FETCH to RUN unconditionally.
- RUN to POST on the engine's done pulse.
- POST to IDLE when the outbound ring has room. POST holds while that ring is full.

The interrupt line is the OR of a done flag, which is high while the outbound ring holds anything, and a sticky error flag.

Registers. All are at 3-bit word offsets.
- 0, command: writing bit0 = 1 enables the channel. A read returns enable in bit0, inbound fetch index in [13:8], producer index in [19:14], consumer index in [25:20] and outbound write index in [31:26].
- 1, inbound base.
- 2, outbound base.
- 3, ring size (read-only).
- 4, inbound free count. A write here is the add-job doorbell.
- 5, outbound full count. A write here is the job-removed doorbell.
- 6, interrupt status: bit0 done, bit1 error. Writing a value with bit1 set clears the error.
- 7, error detail.

Top module: `jring_ctl`

## Requirements
- R1: After reset the free count reads DEPTH, the full count reads 0, status reads 0, the size register reads DEPTH, the command register reads 0 and irq is low.
- R2: Until bit0 of the command register is written as 1, doorbell writes have no effect and no job is started. The enable takes effect on the clock after the write, and it is reported in command bit0.
- R3: An add-job write of N no greater than the free count lowers the free count by N. N = 0 is accepted and changes nothing.
- R4: An add-job write of N greater than the free count is ignored. It sets status bit1 and latches the error detail as {free count in [31:16], N[15:0] in [15:0]}.
- R5: Jobs start one per job_start pulse, in submission order. The inbound index advances by one per start and wraps modulo DEPTH. job_addr equals inbound base + index × DESC_BYTES.
- R6: After job_done, a cpl_write pulse has cpl_addr equal to outbound base + outbound write index × DESC_BYTES, and the full count rises by one. While the full count equals DEPTH, the completion is held and no cpl_write occurs.
- R7: A job-removed write of N no greater than the full count lowers it by N. A larger N is ignored and leaves the count unchanged.
- R8: Status bit0 is 1 exactly when the full count is non-zero. irq equals status bit0 OR status bit1.
- R9: Writing the status register with bit1 set clears the error bit.
- R10: The inbound slot of a job is returned to the free count in the cycle after its job_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| job_start | output | 1 | One-cycle pulse issuing the next job to the engine |
| job_addr | output | 32 | Descriptor address of the issued job |
| job_done | input | 1 | Engine completion pulse for the running job |
| cpl_write | output | 1 | One-cycle pulse writing a completion to the outbound ring |
| cpl_addr | output | 32 | Outbound slot address for the completion |
| irq | output | 1 | Interrupt request |

## Verification
The doorbells are driven with several patterns: a write while the channel is still disabled, a small batch, an empty write of zero, an oversize write that must be refused, and a batch of exactly the ring size. Together these separate count arithmetic from legality checking and from enable gating. Engine latency varies from job to job, and the total number of jobs exceeds the ring size. This shows whether indices wrap and ordering holds when the outbound ring fills and the completion stalls. Removal writes of a partial count, an oversize count and an exact count separate the release arithmetic from its bound. Checking the interrupt across these cases tells the done source apart from the sticky error source.

// File: rtl/jring_pkg.sv
package jring_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_IDLE  = 3'd1,
        ST_FETCH = 3'd2,
        ST_RUN   = 3'd3,
        ST_POST  = 3'd4
    } jr_state_e;

    localparam logic [2:0] OFS_CMD   = 3'd0;
    localparam logic [2:0] OFS_INB   = 3'd1;
    localparam logic [2:0] OFS_OUTB  = 3'd2;
    localparam logic [2:0] OFS_SIZE  = 3'd3;
    localparam logic [2:0] OFS_ADD   = 3'd4;
    localparam logic [2:0] OFS_RMV   = 3'd5;
    localparam logic [2:0] OFS_STAT  = 3'd6;
    localparam logic [2:0] OFS_INFO  = 3'd7;

endpackage

// File: rtl/jring_track.sv
module jring_track #(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          add_en,
    input  logic [CW-1:0] add_n,
    input  logic          sub_en,
    input  logic [CW-1:0] sub_n,
    output logic [CW-1:0] cnt,
    output logic [IW-1:0] head,
    output logic [IW-1:0] tail
);

    logic [CW-1:0] add_v;
    logic [CW-1:0] sub_v;

    always_comb begin
        add_v = add_en ? add_n : '0;
        sub_v = sub_en ? sub_n : '0;
    end

    // indices wrap by truncation to IW bits: DEPTH is a power of two
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            head <= '0;
            tail <= '0;
        end else begin
            cnt  <= cnt + add_v - sub_v;
            tail <= tail + add_v[IW-1:0];
            head <= head + sub_v[IW-1:0];
        end
    end

endmodule

// File: rtl/jring_seq.sv
module jring_seq
    import jring_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enabled,
    input  logic pending,
    input  logic room,
    input  logic job_done,
    output logic launch,
    output logic post_ok
);

    jr_state_e state;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:   if (enabled)  state <= ST_IDLE;
                ST_IDLE:  if (pending)  state <= ST_FETCH;
                ST_FETCH:               state <= ST_RUN;
                ST_RUN:   if (job_done) state <= ST_POST;
                ST_POST:  if (room)     state <= ST_IDLE;
                default:                state <= ST_OFF;
            endcase
        end
    end

    always_comb begin
        launch  = 1'b0;
        post_ok = 1'b0;
        unique case (state)
            ST_FETCH: launch  = 1'b1;
            ST_POST:  post_ok = room;
            default: ;
        endcase
    end

endmodule

// File: rtl/jring_ctl.sv
module jring_ctl
    import jring_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int DESC_BYTES = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        job_start,
    output logic [31:0] job_addr,
    input  logic        job_done,
    output logic        cpl_write,
    output logic [31:0] cpl_addr,
    output logic        irq
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(DEPTH);
    localparam int FW = 6;

    logic          enabled;
    logic [31:0]   in_base;
    logic [31:0]   out_base;
    logic          err;
    logic [31:0]   err_info;
    logic [CW-1:0] in_cnt, out_cnt, avail;
    logic [IW-1:0] in_head, in_tail, out_head, out_tail;
    logic          add_ok, add_bad, rm_ok, launch, post_ok, done_flag;

    assign avail     = CW'(DEPTH) - in_cnt;
    assign add_ok    = wr_en && addr == OFS_ADD && enabled && wdata <= 32'(avail);
    assign add_bad   = wr_en && addr == OFS_ADD && enabled && wdata >  32'(avail);
    assign rm_ok     = wr_en && addr == OFS_RMV && enabled && wdata <= 32'(out_cnt);
    assign done_flag = out_cnt != '0;

    jring_track #(.DEPTH(DEPTH), .CW(CW), .IW(IW)) u_inring (
        .clk(clk), .rst_n(rst_n),
        .add_en(add_ok), .add_n(wdata[CW-1:0]),
        .sub_en(launch), .sub_n(CW'(1)),
        .cnt(in_cnt), .head(in_head), .tail(in_tail)
    );

    jring_track #(.DEPTH(DEPTH), .CW(CW), .IW(IW)) u_outring (
        .clk(clk), .rst_n(rst_n),
        .add_en(post_ok), .add_n(CW'(1)),
        .sub_en(rm_ok), .sub_n(wdata[CW-1:0]),
        .cnt(out_cnt), .head(out_head), .tail(out_tail)
    );

    jring_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .enabled(enabled),
        .pending(in_cnt != '0),
        .room(out_cnt != CW'(DEPTH)),
        .job_done(job_done),
        .launch(launch),
        .post_ok(post_ok)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enabled  <= 1'b0;
            in_base  <= '0;
            out_base <= '0;
            err      <= 1'b0;
            err_info <= '0;
        end else begin
            if (wr_en && addr == OFS_CMD && wdata[0]) enabled <= 1'b1;
            if (wr_en && addr == OFS_INB)  in_base  <= wdata;
            if (wr_en && addr == OFS_OUTB) out_base <= wdata;
            if (wr_en && addr == OFS_STAT && wdata[1]) err <= 1'b0;
            if (add_bad) begin
                err      <= 1'b1;
                err_info <= {16'(avail), wdata[15:0]};
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CMD: begin
                rdata[0]       = enabled;
                rdata[8 +: FW]  = FW'(in_head);
                rdata[14 +: FW] = FW'(in_tail);
                rdata[20 +: FW] = FW'(out_head);
                rdata[26 +: FW] = FW'(out_tail);
            end
            OFS_INB:  rdata = in_base;
            OFS_OUTB: rdata = out_base;
            OFS_SIZE: rdata = 32'(DEPTH);
            OFS_ADD:  rdata = 32'(avail);
            OFS_RMV:  rdata = 32'(out_cnt);
            OFS_STAT: rdata = {30'd0, err, done_flag};
            OFS_INFO: rdata = err_info;
            default:  rdata = '0;
        endcase
    end

    assign job_start = launch;
    assign job_addr  = in_base + 32'(in_head) * 32'(DESC_BYTES);
    assign cpl_write = post_ok;
    assign cpl_addr  = out_base + 32'(out_tail) * 32'(DESC_BYTES);
    assign irq       = done_flag | err;

endmodule

// File: rtl/jring_chk.sv
module jring_chk
    import jring_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enabled,
    input logic          wr_en,
    input logic [2:0]    addr,
    input logic [31:0]   wdata,
    input logic [CW-1:0] in_cnt,
    input logic [CW-1:0] out_cnt,
    input logic          err,
    input logic          job_start,
    input logic          cpl_write,
    input logic          irq
);

    assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |-> !job_start);

    assert_overflow_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_ADD && enabled && wdata > (32'(DEPTH) - 32'(in_cnt))) |=> err);

    assert_single_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        job_start |=> !job_start);

    assert_full_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        32'(out_cnt) <= 32'(DEPTH));

    assert_cpl_raises_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_write |=> irq);

    assert_error_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_STAT && wdata[1]) |=> !err);

endmodule

bind jring_ctl jring_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .enabled(enabled),
    .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .in_cnt(in_cnt), .out_cnt(out_cnt), .err(err),
    .job_start(job_start), .cpl_write(cpl_write), .irq(irq)
);

// File: tb/jring_ctl_bench.sv
module jring_ctl_bench;

    localparam int DEPTH = 8;
    localparam int DESC  = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        job_start, cpl_write, irq;
    logic [31:0] job_addr, cpl_addr;
    logic        job_done = 1'b0;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    jring_ctl #(.DEPTH(DEPTH), .DESC_BYTES(DESC)) u_jring_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .job_start(job_start), .job_addr(job_addr),
        .job_done(job_done), .cpl_write(cpl_write), .cpl_addr(cpl_addr), .irq(irq)
    );

    always #4 clk = ~clk;

    // behavioural reference model
    int  m_ph, m_pend, m_ih, m_it, m_full, m_oh, m_ot;
    bit  m_en, m_err;
    logic [31:0] m_inb, m_outb, m_info;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_pend = 0; m_ih = 0; m_it = 0; m_full = 0; m_oh = 0; m_ot = 0;
            m_en = 0; m_err = 0; m_inb = 0; m_outb = 0; m_info = 0;
        end else begin
            int p0, f0;
            bit e0;
            p0 = m_pend; f0 = m_full; e0 = m_en;
            case (m_ph)
                0: if (e0) m_ph = 1;
                1: if (p0 > 0) m_ph = 2;
                2: begin m_pend--; m_ih = (m_ih + 1) % DEPTH; m_ph = 3; end
                3: if (job_done) m_ph = 4;
                4: if (f0 < DEPTH) begin m_full++; m_ot = (m_ot + 1) % DEPTH; m_ph = 1; end
                default: ;
            endcase
            if (wr_en) begin
                case (addr)
                    3'd0: if (wdata[0]) m_en = 1;
                    3'd1: m_inb = wdata;
                    3'd2: m_outb = wdata;
                    3'd4: if (e0) begin
                        if (wdata <= 32'(DEPTH - p0)) begin
                            m_pend += int'(wdata); m_it = (m_it + int'(wdata)) % DEPTH;
                        end else begin
                            m_err = 1; m_info = {16'(DEPTH - p0), wdata[15:0]};
                        end
                    end
                    3'd5: if (e0 && wdata <= 32'(f0)) begin
                        m_full -= int'(wdata); m_oh = (m_oh + int'(wdata)) % DEPTH;
                    end
                    3'd6: if (wdata[1]) m_err = 0;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {6'(m_ot), 6'(m_oh), 6'(m_it), 6'(m_ih), 7'd0, m_en};
            3'd1: return m_inb;
            3'd2: return m_outb;
            3'd3: return 32'(DEPTH);
            3'd4: return 32'(DEPTH - m_pend);
            3'd5: return 32'(m_full);
            3'd6: return {30'd0, m_err, m_full != 0};
            default: return m_info;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            bit es, ec;
            es = (m_ph == 2);
            ec = (m_ph == 4) && (m_full < DEPTH);
            chk(irq == ((m_full != 0) || m_err), "R8 irq", 32'(irq), 32'((m_full != 0) || m_err));
            chk(job_start == es, "R5 job_start", 32'(job_start), 32'(es));
            chk(cpl_write == ec, "R6 cpl_write", 32'(cpl_write), 32'(ec));
            if (es) chk(job_addr == m_inb + 32'(m_ih * DESC), "R5 job_addr", job_addr, m_inb + 32'(m_ih * DESC));
            if (ec) chk(cpl_addr == m_outb + 32'(m_ot * DESC), "R6 cpl_addr", cpl_addr, m_outb + 32'(m_ot * DESC));
        end
    end

    // stub engine with varying latency
    int cd = 0;
    int lat_sel = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            job_done = 1'b0; cd = 0;
        end else begin
            if (job_done) job_done = 1'b0;
            if (job_start) begin
                cd = 1 + (lat_sel % 3); lat_sel++;
            end else if (cd > 0) begin
                cd--;
                if (cd == 0) job_done = 1'b1;
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_model(input logic [2:0] a, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        chk(rdata == m_read(a), tag, rdata, m_read(a));
    endtask

    task automatic rd_lit(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        chk(rdata == exp, tag, rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            mismatched++; compared++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_lit(3'd4, 32'd8, "R1 free count");
        rd_lit(3'd5, 32'd0, "R1 full count");
        rd_lit(3'd6, 32'd0, "R1 status");
        rd_lit(3'd3, 32'd8, "R1 size");
        rd_lit(3'd0, 32'd0, "R1 command");
        chk(irq == 1'b0, "R1 irq", 32'(irq), 32'd0);
        // R2 doorbell while disabled
        wr(3'd4, 32'd3);
        idle(5);
        rd_lit(3'd4, 32'd8, "R2 disabled add ignored");
        wr(3'd1, 32'h0000_1000);
        wr(3'd2, 32'h0000_8000);
        wr(3'd0, 32'd1);
        idle(2);
        rd_model(3'd0, "R2 enable reported");
        // R3 batch of three
        wr(3'd4, 32'd3);
        rd_model(3'd4, "R3 free count after add");
        idle(40);
        rd_lit(3'd4, 32'd8, "R10 inbound slots returned");
        rd_lit(3'd5, 32'd3, "R6 three completions");
        rd_lit(3'd6, 32'd1, "R8 done bit");
        rd_model(3'd0, "R5 indices");
        // R7 removal
        wr(3'd5, 32'd2);
        rd_lit(3'd5, 32'd1, "R7 partial removal");
        wr(3'd5, 32'd5);
        rd_lit(3'd5, 32'd1, "R7 oversize removal ignored");
        // R4 overflow
        wr(3'd4, 32'd9);
        rd_lit(3'd6, 32'd3, "R4 error bit");
        rd_lit(3'd7, 32'h0008_0009, "R4 error detail");
        rd_lit(3'd4, 32'd8, "R4 free count unchanged");
        // R9 clear
        wr(3'd6, 32'd2);
        rd_lit(3'd6, 32'd1, "R9 error cleared");
        chk(irq == 1'b1, "R8 irq from done", 32'(irq), 32'd1);
        wr(3'd4, 32'd0);
        rd_lit(3'd4, 32'd8, "R3 zero add");
        // full-ring batch, outbound stall
        wr(3'd4, 32'd8);
        rd_model(3'd4, "R3 full batch accepted");
        idle(120);
        rd_lit(3'd5, 32'd8, "R6 outbound full holds");
        rd_lit(3'd4, 32'd8, "R10 all fetched");
        rd_model(3'd0, "R5 wrapped indices");
        wr(3'd5, 32'd3);
        idle(20);
        rd_lit(3'd5, 32'd6, "R6 stalled completion posted");
        wr(3'd5, 32'd6);
        idle(5);
        rd_lit(3'd5, 32'd0, "R7 exact removal");
        rd_lit(3'd6, 32'd0, "R8 status clear");
        chk(irq == 1'b0, "R8 irq low", 32'(irq), 32'd0);
        rd_model(3'd0, "R5 final indices");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule